// File: doc/BRIEF.md
# Delay Tap Update Sequencer

This block reloads the tap setting of a programmable input or output delay line while the design is running. User logic asks for a new delay with a one-cycle request and a requested tap count. The sequencer waits until the delay calibration controller reports ready. It then switches off voltage/temperature tracking and lets the line settle for a parameterised number of cycles. Next it presents the new tap value and issues two load strobes. The first is a plain strobe that stages the value. The second carries the clock enable as well and makes the staged value the active delay. After a second settling period it turns tracking back on and raises a one-cycle completion pulse.

For lines on the receive side, the calibration controller adds a fixed alignment offset to every delay. The sequencer removes that offset from the request before it writes the tap value, and clamps the result to the legal tap range. For transmit-side lines no offset is removed, and a parameter selects which of the two cases applies. A request that arrives while an update is running is held and started after the current one finishes. When the sequence ends, the value read back from the line is compared with the value written.

Top module: `dly_tap_seq`

## Requirements
- R1: After reset, compensation enable is 1, the load and clock enable strobes are 0, busy, done and mismatch are 0, and the presented tap value is 0.
- R2: While the calibration-ready input is low, an accepted request keeps busy at 1 but leaves compensation enabled and issues no load. The sequence continues once ready goes high.
- R3: Compensation enable stays low for at least SETTLE+1 cycles before the first load strobe. During those cycles the new tap value is on the tap output for at least the last cycle, and it does not change through both strobes.
- R4: The first load strobe lasts one cycle with clock enable 0. It is followed in the very next cycle by a one-cycle strobe with load and clock enable both 1. Clock enable is never 1 at any other time.
- R5: Compensation enable returns to 1 no sooner than SETTLE cycles after the second strobe. The done output is 1 for exactly that one cycle, which is the first cycle with compensation enabled again.
- R6: With RX_SIDE=1, the written tap equals the request minus ALIGN_OFS. A request below ALIGN_OFS writes 0. With the defaults, 100 writes 60 and 30 writes 0.
- R7: A result above 2^TAP_W-1 writes 2^TAP_W-1, which is 511 with the defaults. For example, 1000 writes 511 on the receive side.
- R8: With RX_SIDE=0, no offset is removed, so 100 writes 100 and 700 writes 511.
- R9: Busy is 1 from the cycle after a request is accepted until the done cycle, and 0 in the done cycle. A request taken while an update is running, or while another request is already held, is not lost. Once the running update completes, the most recent held value is serviced.
- R10: In the done cycle, mismatch is 1 if the tap readback input differs from the value written, and 0 if the two are equal. It keeps that value until the next done.
- R11: With ready high, done follows an accepted request within 2*SETTLE+6 cycles. At the defaults this is 26 cycles, or 130 ns at 200 MHz, well inside a 2 µs update interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_rdy_i | input | 1 | Delay calibration controller ready |
| req_i | input | 1 | One-cycle update request |
| req_tap_i | input | REQ_W | Requested delay in taps, before offset removal |
| tap_rb_i | input | TAP_W | Tap value read back from the delay line |
| tap_o | output | TAP_W | Tap value driven to the delay line |
| load_o | output | 1 | Load strobe to the delay line |
| ce_o | output | 1 | Clock enable strobe to the delay line |
| vtc_en_o | output | 1 | Voltage/temperature compensation enable |
| busy_o | output | 1 | Update in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mismatch_o | output | 1 | Readback differed from the written value at the last done |

## Verification
Updates are driven with requests that land in the middle of the tap range, below the alignment offset, and far above the range. These show the offset subtraction apart from the clamping at each end. A second instance configured for the transmit side takes the same kind of request and shows that no offset is removed there. Further scenarios hold ready low, post a second request during a running update, and corrupt the readback. These separate the ready gate, the holding of pending requests and the mismatch compare from the strobe ordering and settling windows, which are measured on every update.

// File: rtl/dts_pkg.sv
package dts_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_RDY,
    ST_FREEZE,
    ST_PRESENT,
    ST_LOAD_SEL,
    ST_LOAD_ACT,
    ST_HOLD,
    ST_DONE
  } seq_st_e;
endpackage

// File: rtl/dts_tap_comp.sv
module dts_tap_comp #(
  parameter int REQ_W   = 10,
  parameter int TAP_W   = 9,
  parameter int OFS     = 40,
  parameter bit RX_SIDE = 1'b1
) (
  input  logic [REQ_W-1:0] raw_i,
  output logic [TAP_W-1:0] tap_o
);
  localparam int MAXV = (1 << TAP_W) - 1;
  localparam int CW   = ((REQ_W > TAP_W) ? REQ_W : TAP_W) + 2;

  logic signed [CW-1:0] wide;

  // receive-side lines lose the calibration alignment offset
  generate
    if (RX_SIDE) begin : g_rx
      always_comb wide = $signed({2'b00, raw_i}) - $signed(CW'(OFS));
    end else begin : g_tx
      always_comb wide = $signed({2'b00, raw_i});
    end
  endgenerate

  always_comb begin
    if (wide < 0)                          tap_o = '0;
    else if (wide > $signed(CW'(MAXV)))    tap_o = '1;
    else                                   tap_o = wide[TAP_W-1:0];
  end
endmodule

// File: rtl/dts_settle_timer.sv
module dts_settle_timer #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic en_i,
  output logic hit_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)         cnt_q <= '0;
    else if (en_i && !hit_o)  cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/dts_pend_slot.sv
module dts_pend_slot #(
  parameter int REQ_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_i,
  input  logic [REQ_W-1:0] val_i,
  input  logic             take_i,
  output logic             valid_o,
  output logic [REQ_W-1:0] val_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      val_o   <= '0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      val_o   <= val_i;
    end else if (take_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dly_tap_seq.sv
module dly_tap_seq
  import dts_pkg::*;
#(
  parameter int TAP_W     = 9,
  parameter int REQ_W     = 10,
  parameter int SETTLE    = 10,
  parameter int ALIGN_OFS = 40,
  parameter bit RX_SIDE   = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cal_rdy_i,
  input  logic             req_i,
  input  logic [REQ_W-1:0] req_tap_i,
  input  logic [TAP_W-1:0] tap_rb_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             load_o,
  output logic             ce_o,
  output logic             vtc_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             mismatch_o
);
  seq_st_e state_q, state_d;

  logic             start;
  logic             pend_v;
  logic [REQ_W-1:0] pend_val;
  logic [REQ_W-1:0] start_raw;
  logic [TAP_W-1:0] start_tap;
  logic [TAP_W-1:0] target_q;
  logic             tmr_hit;
  logic             tmr_en;
  logic             tmr_clr;

  // held request has priority; a fresh one arriving with it goes to the slot
  assign start_raw = pend_v ? pend_val : req_tap_i;

  dts_pend_slot #(.REQ_W(REQ_W)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .set_i   (req_i && ((state_q != ST_IDLE) || pend_v)),
    .val_i   (req_tap_i),
    .take_i  (start && pend_v),
    .valid_o (pend_v),
    .val_o   (pend_val)
  );

  dts_tap_comp #(
    .REQ_W   (REQ_W),
    .TAP_W   (TAP_W),
    .OFS     (ALIGN_OFS),
    .RX_SIDE (RX_SIDE)
  ) u_comp (
    .raw_i (start_raw),
    .tap_o (start_tap)
  );

  assign tmr_en  = (state_q == ST_FREEZE) || (state_q == ST_HOLD);
  assign tmr_clr = (state_d != state_q);

  dts_settle_timer #(.LIMIT(SETTLE)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .clr_i (tmr_clr),
    .en_i  (tmr_en),
    .hit_o (tmr_hit)
  );

  always_comb begin
    state_d = state_q;
    start   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (pend_v || req_i) begin
          state_d = ST_WAIT_RDY;
          start   = 1'b1;
        end
      end
      ST_WAIT_RDY: if (cal_rdy_i) state_d = ST_FREEZE;
      ST_FREEZE:   if (tmr_hit)   state_d = ST_PRESENT;
      ST_PRESENT:  state_d = ST_LOAD_SEL;
      ST_LOAD_SEL: state_d = ST_LOAD_ACT;
      ST_LOAD_ACT: state_d = ST_HOLD;
      ST_HOLD:     if (tmr_hit)   state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      target_q <= '0;
    end else begin
      state_q <= state_d;
      if (start) target_q <= start_tap;
    end
  end

  // outputs registered from the next state so they line up with state_q
  always_ff @(posedge clk) begin
    if (rst) begin
      tap_o      <= '0;
      load_o     <= 1'b0;
      ce_o       <= 1'b0;
      vtc_en_o   <= 1'b1;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      mismatch_o <= 1'b0;
    end else begin
      load_o   <= (state_d == ST_LOAD_SEL) || (state_d == ST_LOAD_ACT);
      ce_o     <= (state_d == ST_LOAD_ACT);
      vtc_en_o <= (state_d == ST_IDLE) || (state_d == ST_WAIT_RDY) || (state_d == ST_DONE);
      busy_o   <= !((state_d == ST_IDLE) || (state_d == ST_DONE));
      done_o   <= (state_d == ST_DONE);
      if ((state_d == ST_PRESENT) && (state_q != ST_PRESENT))
        tap_o <= target_q;
      if ((state_d == ST_DONE) && (state_q != ST_DONE))
        mismatch_o <= (tap_rb_i != target_q);
    end
  end
endmodule

// File: rtl/dly_tap_seq_chk.sv
module dly_tap_seq_chk #(
  parameter int TAP_W  = 9,
  parameter int SETTLE = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             cal_rdy_i,
  input logic [TAP_W-1:0] tap_o,
  input logic             load_o,
  input logic             ce_o,
  input logic             vtc_en_o,
  input logic             busy_o,
  input logic             done_o
);
  logic [15:0] low_cnt;
  logic [15:0] post_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt  <= '0;
      post_cnt <= '0;
    end else begin
      if (vtc_en_o)              low_cnt <= '0;
      else if (low_cnt != '1)    low_cnt <= low_cnt + 1'b1;
      if (load_o)                post_cnt <= '0;
      else if (!vtc_en_o && post_cnt != '1) post_cnt <= post_cnt + 1'b1;
    end
  end

  p_rdy_gate_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(vtc_en_o) |-> $past(cal_rdy_i));

  p_load_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    load_o |-> !vtc_en_o);

  p_pre_window_r3: assert property (@(posedge clk) disable iff (rst)
    (load_o && !ce_o) |-> (low_cnt >= 16'(SETTLE + 1)));

  p_tap_steady_r3: assert property (@(posedge clk) disable iff (rst)
    (load_o && ce_o) |-> $stable(tap_o));

  p_sel_then_act_r4: assert property (@(posedge clk) disable iff (rst)
    (load_o && !ce_o) |=> (load_o && ce_o));

  p_ce_paired_r4: assert property (@(posedge clk) disable iff (rst)
    ce_o |-> (load_o && $past(load_o) && !$past(ce_o)));

  p_post_window_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(vtc_en_o) |-> (post_cnt >= 16'(SETTLE)));

  p_done_on_reenable_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $rose(vtc_en_o));

  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_busy_drop_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
endmodule

bind dly_tap_seq dly_tap_seq_chk #(
  .TAP_W  (TAP_W),
  .SETTLE (SETTLE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cal_rdy_i (cal_rdy_i),
  .tap_o     (tap_o),
  .load_o    (load_o),
  .ce_o      (ce_o),
  .vtc_en_o  (vtc_en_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/test_dly_tap_seq.sv
`timescale 1ns/1ps
module test_dly_tap_seq;
  localparam int TAP_W  = 9;
  localparam int REQ_W  = 10;
  localparam int SETTLE = 10;
  localparam int OFS    = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic             cal_rdy = 1'b1;
  logic             req = 1'b0;
  logic [REQ_W-1:0] req_tap = '0;
  logic [TAP_W-1:0] tap_rb;
  logic [TAP_W-1:0] tap_o;
  logic load, ce, vtc_en, busy, done, mism;

  logic             req_tx = 1'b0;
  logic [REQ_W-1:0] req_tap_tx = '0;
  logic [TAP_W-1:0] tap_tx;
  logic load_tx, ce_tx, vtc_tx, busy_tx, done_tx, mism_tx;

  int checks = 0;
  int errors = 0;

  // behavioural delay line: plain load stages, load with enable activates
  logic [TAP_W-1:0] staged = '0;
  logic [TAP_W-1:0] active = '0;
  bit               rb_corrupt = 1'b0;
  always @(posedge clk) begin
    if (load && !ce) staged <= tap_o;
    if (load && ce)  active <= staged;
  end
  assign tap_rb = rb_corrupt ? (staged ^ 9'h001) : staged;

  dly_tap_seq #(.TAP_W(TAP_W), .REQ_W(REQ_W), .SETTLE(SETTLE),
                .ALIGN_OFS(OFS), .RX_SIDE(1'b1)) i_dly_tap_seq (
    .clk(clk), .rst(rst), .cal_rdy_i(cal_rdy), .req_i(req), .req_tap_i(req_tap),
    .tap_rb_i(tap_rb), .tap_o(tap_o), .load_o(load), .ce_o(ce), .vtc_en_o(vtc_en),
    .busy_o(busy), .done_o(done), .mismatch_o(mism));

  dly_tap_seq #(.TAP_W(TAP_W), .REQ_W(REQ_W), .SETTLE(SETTLE),
                .ALIGN_OFS(OFS), .RX_SIDE(1'b0)) i_dly_tap_seq_tx (
    .clk(clk), .rst(rst), .cal_rdy_i(1'b1), .req_i(req_tx), .req_tap_i(req_tap_tx),
    .tap_rb_i(tap_tx), .tap_o(tap_tx), .load_o(load_tx), .ce_o(ce_tx), .vtc_en_o(vtc_tx),
    .busy_o(busy_tx), .done_o(done_tx), .mismatch_o(mism_tx));

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(vtc_en == 1 && load == 0 && ce == 0, "R1", "strobes/compensation after reset",
        {vtc_en, load, ce}, 3'b100);
    chk(busy == 0 && done == 0 && mism == 0, "R1", "flags after reset", {busy, done, mism}, 0);
    chk(tap_o == 0, "R1", "tap after reset", tap_o, 0);
  endtask

  // one full update on the receive instance, measuring every window
  task automatic run_update(input int raw, input int exp_tap, input string rq);
    int cyc = 1, low_pre = 0, post = 0, l1_at = -10;
    bit l1 = 0, l2 = 0;
    int prev_tap = -1;
    @(negedge clk); req = 1'b1; req_tap = REQ_W'(raw);
    @(negedge clk); req = 1'b0;
    while (!done && cyc < 200) begin
      if (load && !ce) begin
        l1 = 1; l1_at = cyc;
        chk(low_pre >= SETTLE + 1, "R3", "frozen cycles before first load", low_pre, SETTLE + 1);
        chk(prev_tap == exp_tap, "R3", "tap presented one cycle ahead", prev_tap, exp_tap);
      end else if (load && ce) begin
        l2 = 1;
        chk(l1 && cyc == l1_at + 1, "R4", "combined strobe follows plain one", cyc, l1_at + 1);
        chk(tap_o == exp_tap, "R3", "tap steady through strobes", tap_o, exp_tap);
      end else if (ce) begin
        chk(0, "R4", "enable without load", ce, 0);
      end else if (!vtc_en) begin
        if (l2) post++; else low_pre++;
      end
      prev_tap = tap_o;
      @(negedge clk); cyc++;
    end
    chk(done == 1, "R5", "done reached", done, 1);
    chk(vtc_en == 1, "R5", "compensation back on at done", vtc_en, 1);
    chk(post >= SETTLE, "R5", "frozen cycles after final load", post, SETTLE);
    chk(tap_o == exp_tap, rq, "written tap", tap_o, exp_tap);
    chk(active == exp_tap, rq, "active delay in line model", active, exp_tap);
    chk(cyc <= 2 * SETTLE + 6, "R11", "request-to-done cycles", cyc, 2 * SETTLE + 6);
    @(negedge clk);
    chk(done == 0, "R5", "done lasts one cycle", done, 0);
    chk(busy == 0, "R9", "idle after update", busy, 0);
  endtask

  task automatic t_not_ready();
    bit bad = 0;
    int n = 0;
    cal_rdy = 1'b0;
    @(negedge clk); req = 1'b1; req_tap = 10'd140;
    @(negedge clk); req = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (!vtc_en || load) bad = 1;
      @(negedge clk);
    end
    chk(!bad, "R2", "no freeze or load while not ready", bad, 0);
    chk(busy == 1, "R2", "busy while waiting for ready", busy, 1);
    cal_rdy = 1'b1;
    while (!done && n < 100) begin @(negedge clk); n++; end
    chk(done == 1 && active == 100, "R2", "update proceeds after ready", active, 100);
    @(negedge clk);
  endtask

  task automatic t_pending();
    int n = 0, dones = 0, first_tap = -1;
    @(negedge clk); req = 1'b1; req_tap = 10'd200;
    @(negedge clk); req = 1'b0;
    repeat (5) @(negedge clk);
    chk(busy == 1, "R9", "busy during update", busy, 1);
    req = 1'b1; req_tap = 10'd300;
    @(negedge clk); req = 1'b0;
    while (dones < 2 && n < 200) begin
      if (done) begin
        dones++;
        if (dones == 1) first_tap = tap_o;
      end
      if (dones < 2) begin @(negedge clk); n++; end
    end
    chk(first_tap == 160, "R9", "first update value", first_tap, 160);
    chk(dones == 2, "R9", "held request serviced", dones, 2);
    chk(active == 260, "R9", "held value active", active, 260);
    @(negedge clk);
  endtask

  task automatic t_mismatch();
    rb_corrupt = 1'b1;
    run_update(90, 50, "R10");
    chk(mism == 1, "R10", "mismatch on corrupted readback", mism, 1);
    rb_corrupt = 1'b0;
    run_update(91, 51, "R10");
    chk(mism == 0, "R10", "mismatch cleared on matching readback", mism, 0);
  endtask

  task automatic tx_update(input int raw, input int exp_tap);
    int n = 0;
    @(negedge clk); req_tx = 1'b1; req_tap_tx = REQ_W'(raw);
    @(negedge clk); req_tx = 1'b0;
    while (!done_tx && n < 200) begin @(negedge clk); n++; end
    chk(done_tx == 1 && tap_tx == exp_tap, "R8", "transmit side keeps full value", tap_tx, exp_tap);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    run_update(100, 60, "R6");
    run_update(30, 0, "R6");
    run_update(41, 1, "R6");
    run_update(1000, 511, "R7");
    tx_update(100, 100);
    tx_update(700, 511);
    t_not_ready();
    t_pending();
    t_mismatch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule